// File: doc/BRIEF.md
# Preemptive Prioritized Interrupt Controller

This block collects interrupt requests from a parameterised set of peripheral lines and from eight request bits that software sets and clears. It routes each request to one or both of two processors. Every source carries a 4-bit priority and a 2-bit steering field. For each processor the block picks the best pending request whose priority is strictly above that processor's current priority, and drives a request line to that processor.

Each processor runs in one of two handshake modes, chosen by its own mode bit. In hardware vector mode the winning source index is driven on a 9-bit vector output, and a one-cycle acknowledge pulse accepts the request. In software vector mode the processor accepts by reading its acknowledge word, which returns the vector. On acceptance the old current priority is pushed onto that processor's stack of preempted priorities. An end-of-interrupt write pops it back. Software can also write the current priority directly, which raises a task to a priority ceiling. Debug operation needs no separate path, because the block behaves the same in every processor state.

A word-addressed register port gives access to the mode bits, the current priorities, the acknowledge and end-of-interrupt words, the software request bits and one configuration word per source.

Top module: `prio_intc`

## Requirements
- R1: After reset, no request output is high, every current priority reads 0, and every source configuration word reads 0x10 (steering to processor 0 only, priority 0).
- R2: A peripheral request that is sampled high on a clock edge drives the matching request output high after the third edge counted from that one. The output is low after the first and second edges.
- R3: Bits [5:4] of a source configuration word (word 16+source) steer the source: bit 4 routes it to processor 0 and bit 5 routes it to processor 1. With both bits set, both processors are requested.
- R4: Sources 0..7 are the software bits and source 8+k is peripheral input k. The vector is the source index. Among eligible sources the highest priority wins, and on a tie the lowest index wins.
- R5: A source requests a processor only when its priority (bits [3:0]) is strictly greater than that processor's current priority. Priority 0 therefore never raises a request.
- R6: Mode word 0 bit p set selects hardware vector mode for processor p. In that mode the vector appears on the processor's 9-bit slice of irq_vec_o. An irq_ack_i pulse while the request is high accepts it: the request drops and the current priority becomes the source's priority. In software vector mode the vector slice is 0.
- R7: Reading acknowledge word 3+p returns bit 31 = request pending and bits [8:0] = vector. In software vector mode that read accepts the request. In hardware vector mode the read has no side effect. With nothing pending the read returns 0.
- R8: Writing end-of-interrupt word 5+p restores the most recently pushed priority. When the stack is empty the write leaves the current priority unchanged.
- R9: Writing current priority word 1+p (bits [3:0]) replaces the current priority directly. Requests at or below the new value are masked, and requests above it are raised.
- R10: Writing word 7 sets the software request bits given by the 1s in bits [7:0]. Writing word 8 clears the bits given by its 1s. Reading word 7 returns the bits.
- R11: Priorities nest fifteen deep. Fifteen accepts at rising priorities 1..15 leave a current priority of 15, and fifteen end-of-interrupt writes unwind it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_req_i | input | NUM_PERIPH | Peripheral request lines, level |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (acknowledge side effect) |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_ack_i | input | 2 | Per-processor acknowledge pulse, hardware vector mode |
| irq_o | output | 2 | Per-processor interrupt request |
| irq_vec_o | output | 18 | Per-processor 9-bit vector, processor p at bits [9p+8:9p] |

## Verification
The bench times the request path edge by edge. A design with a missing or extra pipeline stage therefore shows the request one cycle early or late. Equal-priority ties and a source whose priority equals the current level are driven on purpose: a wrong tie order presents the higher index, and a non-strict compare re-raises the interrupt that was just accepted. The stack is filled to fifteen levels and then popped past empty. An off-by-one in its count loses the bottom level or corrupts the current priority on the extra pop. In hardware vector mode the acknowledge word is read and the current priority is checked afterwards, which catches a design that lets the read accept in that mode.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_CPU    = 2;
  localparam int SW_SRC     = 8;
  localparam int PRI_W      = 4;
  localparam int VEC_W      = 9;
  localparam int STK_DEPTH  = 15;

  // word addresses
  localparam int A_MODE  = 0;
  localparam int A_CPR   = 1;   // + cpu
  localparam int A_ACK   = 3;   // + cpu
  localparam int A_EOI   = 5;   // + cpu
  localparam int A_SWSET = 7;
  localparam int A_SWCLR = 8;
  localparam int A_CFG   = 16;  // + source

  typedef struct packed {
    logic [NUM_CPU-1:0] steer;
    logic [PRI_W-1:0]   pri;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{steer: 2'b01, pri: '0};
endpackage

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*PRI_W-1:0] pri_i,
  input  logic [PRI_W-1:0]         floor_i,
  output logic                     valid_o,
  output logic [VEC_W-1:0]         idx_o,
  output logic [PRI_W-1:0]         pri_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    pri_o   = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (pri_i[i*PRI_W +: PRI_W] > floor_i) &&
          (!valid_o || (pri_i[i*PRI_W +: PRI_W] > pri_o))) begin
        valid_o = 1'b1;
        idx_o   = VEC_W'(i);
        pri_o   = pri_i[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack #(
  parameter int DEPTH = 15,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[cnt_q - 1'b1];

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[cnt_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full)    cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/prio_intc_cpu.sv
module prio_intc_cpu
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*PRI_W-1:0] pri_i,
  input  logic                     hw_mode_i,
  input  logic                     ack_i,
  input  logic                     ack_rd_i,
  input  logic                     eoi_i,
  input  logic                     cpr_we_i,
  input  logic [PRI_W-1:0]         cpr_wdata_i,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [PRI_W-1:0]         irq_pri_o,
  output logic [PRI_W-1:0]         cur_pri_o,
  output logic                     acc_o
);
  logic             arb_valid;
  logic [VEC_W-1:0] arb_idx;
  logic [PRI_W-1:0] arb_pri;
  logic [PRI_W-1:0] cur_q, stk_top;
  logic             stk_empty;
  logic             win_v_q, irq_q;
  logic [VEC_W-1:0] win_vec_q, vec_q;
  logic [PRI_W-1:0] win_pri_q, pri_q;
  logic             accept, flush;

  prio_intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i   (req_i),
    .pri_i   (pri_i),
    .floor_i (cur_q),
    .valid_o (arb_valid),
    .idx_o   (arb_idx),
    .pri_o   (arb_pri)
  );

  assign accept = irq_q & (hw_mode_i ? ack_i : ack_rd_i);
  // any change of the current level discards in-flight winners
  assign flush  = accept | eoi_i | cpr_we_i;

  prio_intc_stack #(.DEPTH(STK_DEPTH), .W(PRI_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .pop_i   (eoi_i & ~accept),
    .data_i  (cur_q),
    .top_o   (stk_top),
    .empty_o (stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cur_q <= '0;
    else if (accept)                cur_q <= pri_q;
    else if (eoi_i && !stk_empty)   cur_q <= stk_top;
    else if (cpr_we_i && !eoi_i)    cur_q <= cpr_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_v_q   <= 1'b0;
      win_vec_q <= '0;
      win_pri_q <= '0;
      irq_q     <= 1'b0;
      vec_q     <= '0;
      pri_q     <= '0;
    end else begin
      win_v_q   <= arb_valid & ~flush;
      win_vec_q <= arb_idx;
      win_pri_q <= arb_pri;
      irq_q     <= win_v_q & ~flush;
      vec_q     <= win_vec_q;
      pri_q     <= win_pri_q;
    end
  end

  assign irq_o     = irq_q;
  assign vec_o     = vec_q;
  assign irq_pri_o = pri_q;
  assign cur_pri_o = cur_q;
  assign acc_o     = accept;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_PERIPH = 24,
  parameter int ADDR_W     = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PERIPH-1:0]    per_req_i,
  input  logic                     reg_we_i,
  input  logic                     reg_re_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  input  logic [NUM_CPU-1:0]       irq_ack_i,
  output logic [NUM_CPU-1:0]       irq_o,
  output logic [NUM_CPU*VEC_W-1:0] irq_vec_o
);
  localparam int NUM_SRC = NUM_PERIPH + SW_SRC;

  src_cfg_t                          cfg_q [NUM_SRC];
  logic [NUM_PERIPH-1:0]             per_q;
  logic [SW_SRC-1:0]                 sw_q;
  logic [NUM_CPU-1:0]                mode_q;
  logic [NUM_SRC-1:0]                pend;
  logic [NUM_SRC*PRI_W-1:0]          pri_flat;
  logic [NUM_SRC*NUM_CPU-1:0]        steer_flat;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]   req_cpu;

  logic [NUM_CPU-1:0]                irq_w, acc_w, ack_rd, eoi_w, cpr_we;
  logic [NUM_CPU-1:0][VEC_W-1:0]     vec_w;
  logic [NUM_CPU-1:0][PRI_W-1:0]     cur_pri_w, irq_pri_w;

  // request capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) per_q <= '0;
    else         per_q <= per_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '0;
      mode_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(A_SWSET)) sw_q <= sw_q | reg_wdata_i[SW_SRC-1:0];
      if (reg_addr_i == ADDR_W'(A_SWCLR)) sw_q <= sw_q & ~reg_wdata_i[SW_SRC-1:0];
      if (reg_addr_i == ADDR_W'(A_MODE))  mode_q <= reg_wdata_i[NUM_CPU-1:0];
    end
  end

  assign pend = {per_q, sw_q};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[i] <= CFG_RST;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_CFG + i))
        cfg_q[i] <= src_cfg_t'(reg_wdata_i[$bits(src_cfg_t)-1:0]);
    end
    assign pri_flat[i*PRI_W +: PRI_W]       = cfg_q[i].pri;
    assign steer_flat[i*NUM_CPU +: NUM_CPU] = cfg_q[i].steer;
  end

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_cpu
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      assign req_cpu[p][i] = pend[i] & cfg_q[i].steer[p];
    end

    assign ack_rd[p] = reg_re_i && (reg_addr_i == ADDR_W'(A_ACK + p));
    assign eoi_w[p]  = reg_we_i && (reg_addr_i == ADDR_W'(A_EOI + p));
    assign cpr_we[p] = reg_we_i && (reg_addr_i == ADDR_W'(A_CPR + p));

    prio_intc_cpu #(.NUM_SRC(NUM_SRC)) u_cpu (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_cpu[p]),
      .pri_i       (pri_flat),
      .hw_mode_i   (mode_q[p]),
      .ack_i       (irq_ack_i[p]),
      .ack_rd_i    (ack_rd[p]),
      .eoi_i       (eoi_w[p]),
      .cpr_we_i    (cpr_we[p]),
      .cpr_wdata_i (reg_wdata_i[PRI_W-1:0]),
      .irq_o       (irq_w[p]),
      .vec_o       (vec_w[p]),
      .irq_pri_o   (irq_pri_w[p]),
      .cur_pri_o   (cur_pri_w[p]),
      .acc_o       (acc_w[p])
    );

    assign irq_vec_o[p*VEC_W +: VEC_W] = mode_q[p] ? vec_w[p] : '0;
  end

  assign irq_o = irq_w;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_MODE))  reg_rdata_o = 32'(mode_q);
    if (reg_addr_i == ADDR_W'(A_SWSET)) reg_rdata_o = 32'(sw_q);
    for (int p = 0; p < NUM_CPU; p++) begin
      if (reg_addr_i == ADDR_W'(A_CPR + p)) reg_rdata_o = 32'(cur_pri_w[p]);
      if (reg_addr_i == ADDR_W'(A_ACK + p))
        reg_rdata_o = irq_w[p] ? {1'b1, {(32-1-VEC_W){1'b0}}, vec_w[p]} : '0;
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr_i == ADDR_W'(A_CFG + i)) reg_rdata_o = 32'(cfg_q[i]);
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_PERIPH = 24,
  parameter int ADDR_W     = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              irq_i,
  input logic [1:0][8:0]         vec_i,
  input logic [1:0][3:0]         cur_pri_i,
  input logic [1:0][3:0]         irq_pri_i,
  input logic [1:0]              acc_i,
  input logic [(NUM_PERIPH+8)*2-1:0] steer_i,
  input logic                    reg_we_i,
  input logic [ADDR_W-1:0]       reg_addr_i,
  input logic [31:0]             reg_wdata_i
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    assert_irq_above_cur_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[p] |-> (irq_pri_i[p] > cur_pri_i[p]));

    assert_steer_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[p] |-> steer_i[int'(vec_i[p])*2 + p]);

    assert_accept_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i[p] |=> (cur_pri_i[p] == $past(irq_pri_i[p])));

    assert_accept_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i[p] |=> !irq_i[p]);

    assert_cpr_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_W'(1 + p) && !acc_i[p])
        |=> (cur_pri_i[p] == $past(reg_wdata_i[3:0])));
  end
endmodule

bind prio_intc prio_intc_chk #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_w),
  .vec_i       (vec_w),
  .cur_pri_i   (cur_pri_w),
  .irq_pri_i   (irq_pri_w),
  .acc_i       (acc_w),
  .steer_i     (steer_flat),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
  localparam int NP = 24;
  localparam int AW = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NP-1:0] per_req = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ack = '0;
  logic [1:0]  irq;
  logic [17:0] vec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit hw_b [2] = '{1'b0, 1'b0};
  bit prev_irq [2] = '{1'b0, 1'b0};
  int exp_q0 [$];
  int exp_q1 [$];

  always #4 clk_i = ~clk_i;

  prio_intc #(.NUM_PERIPH(NP), .ADDR_W(AW)) u_prio_intc (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_req_i(per_req),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
  );

  task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input int a, input int unsigned d);
    @(negedge clk_i);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    re = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk_i);
    re = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int unsigned exp, input string tag);
    logic [31:0] d;
    bus_rd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic hw_ack(input logic [1:0] m);
    ack = m;
    @(negedge clk_i);
    ack = '0;
  endtask

  task automatic push_exp(input int p, input int v);
    if (p == 0) exp_q0.push_back(v); else exp_q1.push_back(v);
  endtask

  // scoreboard monitor: every rising request pops one expected vector
  task automatic mon_one(input int p);
    int v, e;
    bit empty;
    if (irq[p] && !prev_irq[p]) begin
      v = int'(vec[p*9 +: 9]);
      empty = (p == 0) ? (exp_q0.size() == 0) : (exp_q1.size() == 0);
      if (empty) begin
        check(1'b0, $sformatf("R4 unexpected request cpu%0d", p), v, 0);
      end else begin
        e = (p == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
        if (!hw_b[p]) e = 0;
        check(v == e, $sformatf("R4/R6 vector cpu%0d", p), v, e);
      end
    end
    prev_irq[p] = irq[p];
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      mon_one(0);
      mon_one(1);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", irq, 0);
    rd_chk(1, 0, "R1 cpr0 reset");
    rd_chk(2, 0, "R1 cpr1 reset");
    rd_chk(16 + 8, 32'h10, "R1 cfg reset");
    bus_wr(0, 3); hw_b[0] = 1; hw_b[1] = 1;

    // R2 latency, source 8 priority 5
    bus_wr(16 + 8, 32'h15);
    push_exp(0, 8);
    per_req[0] = 1'b1;
    @(negedge clk_i); check(irq[0] == 1'b0, "R2 low after edge 1", irq[0], 0);
    @(negedge clk_i); check(irq[0] == 1'b0, "R2 low after edge 2", irq[0], 0);
    @(negedge clk_i); check(irq[0] == 1'b1, "R2 high after edge 3", irq[0], 1);
    hw_ack(2'b01);
    check(irq[0] == 1'b0, "R6 drop on ack", irq[0], 0);
    per_req[0] = 1'b0;
    rd_chk(1, 5, "R6 cur after ack");
    bus_wr(5, 0);
    rd_chk(1, 0, "R8 eoi restores 0");

    // R4 tie and priority order
    bus_wr(16 + 11, 32'h17);
    bus_wr(16 + 13, 32'h17);
    bus_wr(16 + 9, 32'h14);
    push_exp(0, 11);
    per_req[3] = 1'b1; per_req[5] = 1'b1; per_req[1] = 1'b1;
    cyc(4);
    check(vec[8:0] == 9'd11, "R4 lowest index on tie", vec[8:0], 11);
    hw_ack(2'b01);
    rd_chk(1, 7, "R6 cur 7");
    cyc(5);
    check(irq[0] == 1'b0, "R5 equal priority blocked", irq[0], 0);
    push_exp(0, 13);
    bus_wr(16 + 13, 32'h19);
    cyc(4);
    check(irq[0] == 1'b1 && vec[8:0] == 9'd13, "R4 higher preempts", vec[8:0], 13);
    hw_ack(2'b01);
    per_req = '0;
    cyc(2);
    bus_wr(5, 0); rd_chk(1, 7, "R8 pop to 7");
    bus_wr(5, 0); rd_chk(1, 0, "R8 pop to 0");
    bus_wr(5, 0); rd_chk(1, 0, "R8 empty pop unchanged");

    // R3 steering
    bus_wr(16 + 10, 32'h33);
    push_exp(0, 10); push_exp(1, 10);
    per_req[2] = 1'b1;
    cyc(4);
    check(irq == 2'b11, "R3 both processors", irq, 3);
    hw_ack(2'b11);
    rd_chk(1, 3, "R3 cpu0 level");
    rd_chk(2, 3, "R3 cpu1 level");
    per_req[2] = 1'b0;
    cyc(2);
    bus_wr(5, 0); bus_wr(6, 0);
    bus_wr(16 + 12, 32'h22);
    push_exp(1, 12);
    per_req[4] = 1'b1;
    cyc(4);
    check(irq == 2'b10, "R3 processor 1 only", irq, 2);
    check(vec[17:9] == 9'd12, "R3 cpu1 vector", vec[17:9], 12);
    hw_ack(2'b10);
    per_req[4] = 1'b0;
    cyc(2);
    bus_wr(6, 0);

    // R7 software vector mode on cpu0, software source 3
    bus_wr(0, 2); hw_b[0] = 0;
    bus_wr(16 + 3, 32'h16);
    push_exp(0, 3);
    bus_wr(7, 32'h08);
    cyc(4);
    check(irq[0] == 1'b1 && vec[8:0] == 9'd0, "R6 sw mode vector zero", vec[8:0], 0);
    rd_chk(3, 32'h80000003, "R7 ack read vector");
    rd_chk(1, 6, "R7 read accepts");
    rd_chk(7, 32'h08, "R10 sw bits read");
    bus_wr(8, 32'h08);
    rd_chk(7, 0, "R10 sw bit cleared");
    cyc(2);
    bus_wr(5, 0);
    cyc(3);
    rd_chk(3, 0, "R7 nothing pending");
    bus_wr(0, 3); hw_b[0] = 1;
    push_exp(0, 3);
    bus_wr(7, 32'h08);
    cyc(4);
    rd_chk(3, 32'h80000003, "R7 hw mode read value");
    rd_chk(1, 0, "R7 hw mode read no accept");
    check(irq[0] == 1'b1, "R7 request kept", irq[0], 1);
    hw_ack(2'b01);
    bus_wr(8, 32'h08);
    cyc(2);
    bus_wr(5, 0);

    // R9 current priority write
    bus_wr(1, 8);
    per_req[0] = 1'b1;
    cyc(5);
    check(irq[0] == 1'b0, "R9 masked by ceiling", irq[0], 0);
    push_exp(0, 8);
    bus_wr(1, 4);
    cyc(4);
    check(irq[0] == 1'b1, "R9 lowered ceiling", irq[0], 1);
    hw_ack(2'b01);
    rd_chk(1, 5, "R9 accept over written level");
    per_req[0] = 1'b0;
    cyc(2);
    bus_wr(5, 0);
    rd_chk(1, 4, "R8 pop to written level");
    bus_wr(1, 0);

    // R11 fifteen nested levels
    for (int k = 0; k < 15; k++) begin
      bus_wr(24 + k, 32'h10 | (k + 1));
      push_exp(0, 8 + k);
      per_req[k] = 1'b1;
      cyc(4);
      hw_ack(2'b01);
    end
    rd_chk(1, 15, "R11 full nesting");
    per_req = '0;
    cyc(2);
    bus_wr(5, 0);
    rd_chk(1, 14, "R11 first unwind");
    for (int k = 0; k < 14; k++) bus_wr(5, 0);
    rd_chk(1, 0, "R11 fully unwound");
    bus_wr(5, 0);
    rd_chk(1, 0, "R8 pop past empty");

    // R5 priority 0 never requests
    bus_wr(16 + 31, 32'h10);
    per_req[23] = 1'b1;
    cyc(5);
    check(irq[0] == 1'b0, "R5 priority 0 silent", irq[0], 0);
    per_req = '0;
    cyc(3);

    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R4 scoreboard drained",
          exp_q0.size() + exp_q1.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule